// File: doc/BRIEF.md
# Mode-Banked Register File with Exception Entry

This block holds the architectural register state of a 32-bit processor core: sixteen general registers as seen by software, the extra private copies that some operating modes own, a current status register and one saved status register for each privileged mode. The low five bits of the current status register name the operating mode, and every register access is steered to the physical copy that belongs to that mode. Changing the mode field is enough to change the visible bank; nothing is copied.

Alongside the normal read and write ports, a user-view port reaches the user-mode copies of registers 8 to 14 from any mode, for privileged block transfers that must touch user state. A single-cycle exception entry takes a 3-bit cause code. In one clock edge it changes the mode, keeps the old status in the new mode's saved status register, writes a return link into the new mode's register 14, loads the vector address into the program counter (register 15) and sets the interrupt mask bits.

Top module: `bank_regfile`

## Requirements
- R1: After reset every register and saved status register reads zero, the program counter is 0 and the current status is 0x00000013 (supervisor, no mask bits).
- R2: A write to the current status register keeps bits [31:28] and [7:0] of the data and clears bits [27:8].
- R3: Mode 0x11 sees its own copies of registers 8 to 14; registers 0 to 7 and 15 are shared with every other mode.
- R4: Modes 0x12, 0x13, 0x17 and 0x1B each see their own copies of registers 13 and 14 only; registers 8 to 12 are the user copies.
- R5: Modes 0x10 and 0x1F use the user copies of every register, and any mode code not listed in R3 and R4 does the same.
- R6: Each of modes 0x11, 0x12, 0x13, 0x17 and 0x1B has its own saved status register, read and written through the saved-status port according to the current mode; in the other modes that port reads zero and its writes have no effect.
- R7: The user-view port reads and writes the user copy of the addressed register whatever the current mode.
- R8: An exception with code 0..7 enters mode 0x13, 0x1B, 0x13, 0x17, 0x17, (code 5: unchanged), 0x12, 0x11 respectively, and the previous current status is placed in the new mode's saved status register.
- R9: On exception entry register 14 of the new mode receives the old program counter plus 0, 4, 4, 4, 8, 0, 4, 4 for codes 0..7, and the program counter becomes 4 times the code.
- R10: Code 7 sets status bit 6 and code 6 sets status bit 7; other codes leave both bits as they were.
- R11: Code 5 leaves the mode unchanged, yet still writes the link into the current mode's register 14, sets the program counter to 20 and saves the status into the current mode's saved status register if it has one.
- R12: When an exception request and any write port are active in the same cycle, the exception takes effect and the writes are dropped.
- R13: Both read ports are combinational and select the bank of the mode held in the current status register in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Register index, read port A |
| rd_a_data | output | XLEN | Read data, port A |
| rd_b_idx | input | 4 | Register index, read port B |
| rd_b_data | output | XLEN | Read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | XLEN | Register write data |
| usr_we | input | 1 | User-view write enable |
| usr_idx | input | 4 | User-view register index |
| usr_wdata | input | XLEN | User-view write data |
| usr_rdata | output | XLEN | User-view read data |
| cur_psr_we | input | 1 | Current status write enable |
| cur_psr_wdata | input | XLEN | Current status write data |
| cur_psr | output | XLEN | Current status register |
| sav_psr_we | input | 1 | Saved status write enable |
| sav_psr_wdata | input | XLEN | Saved status write data |
| sav_psr | output | XLEN | Saved status of the current mode |
| exc_req | input | 1 | Exception entry request |
| exc_code | input | 3 | Exception cause code |

## Verification
The bench builds the block with its default XLEN of 32, so the status bit positions of the mask and mode fields, the cleared middle bits and the full 32-bit link arithmetic are all observed as they will be used. At that width every mode code, every exception code in a chained sequence of entries, the reserved code from a mode with and without a saved status register, and unknown mode codes are within reach of directed tests.

// File: rtl/bank_regfile.sv
module bank_regfile #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [3:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            usr_we,
  input  logic [3:0]      usr_idx,
  input  logic [XLEN-1:0] usr_wdata,
  output logic [XLEN-1:0] usr_rdata,
  input  logic            cur_psr_we,
  input  logic [XLEN-1:0] cur_psr_wdata,
  output logic [XLEN-1:0] cur_psr,
  input  logic            sav_psr_we,
  input  logic [XLEN-1:0] sav_psr_wdata,
  output logic [XLEN-1:0] sav_psr,
  input  logic            exc_req,
  input  logic [2:0]      exc_code
);
  localparam int NPHYS = 31;
  localparam logic [XLEN-1:0] PSR_KEEP = {4'hF, {(XLEN-12){1'b0}}, 8'hFF};
  localparam logic [XLEN-1:0] PSR_RESET = XLEN'(5'h13);

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      5'h11:   return 3'd1;
      5'h12:   return 3'd2;
      5'h13:   return 3'd3;
      5'h17:   return 3'd4;
      5'h1B:   return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [4:0] phys(input logic [3:0] i, input logic [2:0] b);
    if (i < 4'd8 || i == 4'd15 || b == 3'd0) return {1'b0, i};
    if (b == 3'd1) return 5'd8 + {1'b0, i};
    if (i < 4'd13) return {1'b0, i};
    return 5'd23 + 5'({b - 3'd2, 1'b0}) + 5'(i - 4'd13);
  endfunction

  function automatic logic [4:0] entry_mode(input logic [2:0] c, input logic [4:0] cur);
    case (c)
      3'd1:       return 5'h1B;
      3'd3, 3'd4: return 5'h17;
      3'd5:       return cur;
      3'd6:       return 5'h12;
      3'd7:       return 5'h11;
      default:    return 5'h13;
    endcase
  endfunction

  function automatic logic [3:0] link_ofs(input logic [2:0] c);
    case (c)
      3'd0, 3'd5: return 4'd0;
      3'd4:       return 4'd8;
      default:    return 4'd4;
    endcase
  endfunction

  logic [XLEN-1:0] rf   [NPHYS];
  logic [XLEN-1:0] spsr [1:5];
  logic [XLEN-1:0] psr_q;

  logic [2:0] cur_bank, new_bank;
  logic [4:0] new_mode;

  assign cur_bank = bank_of(psr_q[4:0]);
  assign new_mode = entry_mode(exc_code, psr_q[4:0]);
  assign new_bank = bank_of(new_mode);

  assign rd_a_data = rf[phys(rd_a_idx, cur_bank)];
  assign rd_b_data = rf[phys(rd_b_idx, cur_bank)];
  assign usr_rdata = rf[phys(usr_idx, 3'd0)];
  assign cur_psr   = psr_q;
  assign sav_psr   = (cur_bank == 3'd0) ? '0 : spsr[cur_bank];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NPHYS; k++) rf[k] <= '0;
      for (int k = 1; k <= 5; k++) spsr[k] <= '0;
      psr_q <= PSR_RESET;
    end else if (exc_req) begin
      rf[phys(4'd14, new_bank)] <= rf[15] + XLEN'(link_ofs(exc_code));
      rf[15] <= XLEN'({exc_code, 2'b00});
      if (new_bank != 3'd0) spsr[new_bank] <= psr_q;
      psr_q <= {psr_q[XLEN-1:8],
                psr_q[7] | (exc_code == 3'd6),
                psr_q[6] | (exc_code == 3'd7),
                psr_q[5], new_mode};
    end else begin
      if (wr_en) rf[phys(wr_idx, cur_bank)] <= wr_data;
      if (usr_we) rf[phys(usr_idx, 3'd0)] <= usr_wdata;
      if (sav_psr_we && cur_bank != 3'd0) spsr[cur_bank] <= sav_psr_wdata;
      if (cur_psr_we) psr_q <= cur_psr_wdata & PSR_KEEP;
    end
  end
endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cur_psr_we,
  input logic [XLEN-1:0] cur_psr_wdata,
  input logic [XLEN-1:0] cur_psr,
  input logic [XLEN-1:0] sav_psr,
  input logic            exc_req,
  input logic [2:0]      exc_code
);
  // R2
  psr_mid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_psr[27:8] == '0);

  // R2
  psr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_psr_we && !exc_req |=> cur_psr == ($past(cur_psr_wdata) & {4'hF, {(XLEN-12){1'b0}}, 8'hFF}));

  // R8
  saved_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && exc_code != 3'd5 |=> sav_psr == $past(cur_psr));

  // R10
  fiq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && exc_code == 3'd7 |=> cur_psr[4:0] == 5'h11 && cur_psr[6]);

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && exc_code == 3'd6 |=> cur_psr[4:0] == 5'h12 && cur_psr[7]);

  // R11
  reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && exc_code == 3'd5 |=> $stable(cur_psr[4:0]));
endmodule

bind bank_regfile bank_regfile_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_psr_we(cur_psr_we), .cur_psr_wdata(cur_psr_wdata),
  .cur_psr(cur_psr), .sav_psr(sav_psr), .exc_req(exc_req), .exc_code(exc_code)
);

// File: tb/tb_bank_regfile.sv
`timescale 1ns/1ps
module tb_bank_regfile;
  localparam int XLEN = 32;
  logic clk = 0, rst_n = 0;
  logic [3:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0, usr_idx = 0;
  logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data = 0, usr_wdata = 0, usr_rdata;
  logic [XLEN-1:0] cur_psr_wdata = 0, cur_psr, sav_psr_wdata = 0, sav_psr;
  logic wr_en = 0, usr_we = 0, cur_psr_we = 0, sav_psr_we = 0, exc_req = 0;
  logic [2:0] exc_code = 0;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  bank_regfile #(.XLEN(XLEN)) dut (.*);

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic rd(input logic [3:0] i, output logic [XLEN-1:0] d);
    rd_a_idx = i; #1; d = rd_a_data;
  endtask

  task automatic wreg(input logic [3:0] i, input logic [XLEN-1:0] d);
    wr_en = 1; wr_idx = i; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic setpsr(input logic [XLEN-1:0] d);
    cur_psr_we = 1; cur_psr_wdata = d; tick(); cur_psr_we = 0;
  endtask

  task automatic setsav(input logic [XLEN-1:0] d);
    sav_psr_we = 1; sav_psr_wdata = d; tick(); sav_psr_we = 0;
  endtask

  task automatic exc(input logic [2:0] c);
    exc_req = 1; exc_code = c; tick(); exc_req = 0;
  endtask

  task automatic t_reset();
    logic [XLEN-1:0] d;
    chk("R1 status", cur_psr, 32'h13);
    rd(4'd15, d); chk("R1 pc", d, 0);
    rd(4'd14, d); chk("R1 r14", d, 0);
    rd(4'd3, d);  chk("R1 r3", d, 0);
    chk("R1 saved", sav_psr, 0);
  endtask

  task automatic t_mask();
    setpsr(32'hFFFF_FFFF);
    chk("R2 mask", cur_psr, 32'hF000_00FF);
    setpsr(32'h0ABC_DE10);
    chk("R2 mask user", cur_psr, 32'h0000_0010);
  endtask

  task automatic t_banks();
    logic [XLEN-1:0] d;
    for (int i = 8; i <= 14; i++) wreg(4'(i), 32'h100 + i);
    wreg(4'd3, 32'h33);
    setpsr(32'h11);
    rd(4'd8, d);  chk("R3 fiq r8 private", d, 0);
    rd(4'd14, d); chk("R3 fiq r14 private", d, 0);
    rd(4'd3, d);  chk("R3 fiq r3 shared", d, 32'h33);
    wreg(4'd8, 32'hF8);
    rd(4'd8, d);  chk("R3 fiq r8 write", d, 32'hF8);
    setpsr(32'h12);
    rd(4'd8, d);  chk("R4 irq r8 shared", d, 32'h108);
    rd(4'd12, d); chk("R4 irq r12 shared", d, 32'h10C);
    rd(4'd13, d); chk("R4 irq r13 private", d, 0);
    wreg(4'd13, 32'hA13);
    setpsr(32'h17);
    rd(4'd13, d); chk("R4 abt r13 private", d, 0);
    setpsr(32'h12);
    rd(4'd13, d); chk("R4 irq r13 kept", d, 32'hA13);
    setpsr(32'h10);
    rd(4'd13, d); chk("R4 user r13", d, 32'h10D);
    rd(4'd8, d);  chk("R3 user r8 untouched", d, 32'h108);
    setpsr(32'h1F);
    rd(4'd13, d); chk("R5 system r13", d, 32'h10D);
    setpsr(32'h05);
    rd(4'd14, d); chk("R5 unknown mode r14", d, 32'h10E);
    setpsr(32'h11);
    rd_b_idx = 4'd8; rd_a_idx = 4'd9; #1;
    chk("R13 port b fiq", rd_b_data, 32'hF8);
    chk("R13 port a fiq", rd_a_data, 0);
  endtask

  task automatic t_saved();
    setpsr(32'h12);
    setsav(32'h1234_5678);
    chk("R6 irq saved", sav_psr, 32'h1234_5678);
    setpsr(32'h17);
    chk("R6 abt saved separate", sav_psr, 0);
    setsav(32'h9);
    setpsr(32'h10);
    chk("R6 user saved reads zero", sav_psr, 0);
    setsav(32'hDEAD);
    chk("R6 user saved write ignored", sav_psr, 0);
    setpsr(32'h12);
    chk("R6 irq saved kept", sav_psr, 32'h1234_5678);
    setpsr(32'h17);
    chk("R6 abt saved kept", sav_psr, 32'h9);
  endtask

  task automatic t_userport();
    logic [XLEN-1:0] d;
    setpsr(32'h11);
    usr_idx = 4'd8; #1; chk("R7 user view read", usr_rdata, 32'h108);
    usr_we = 1; usr_idx = 4'd9; usr_wdata = 32'h555; tick(); usr_we = 0;
    rd(4'd9, d); chk("R7 fiq r9 unchanged", d, 0);
    setpsr(32'h10);
    rd(4'd9, d); chk("R7 user r9 written", d, 32'h555);
  endtask

  task automatic t_exc();
    logic [XLEN-1:0] d;
    setpsr(32'hA000_0010);
    wreg(4'd15, 32'h1000);
    exc(3'd6);
    chk("R8 irq mode", cur_psr, 32'hA000_0092);
    chk("R8 irq saved", sav_psr, 32'hA000_0010);
    rd(4'd14, d); chk("R9 irq link", d, 32'h1004);
    rd(4'd15, d); chk("R9 irq pc", d, 32'h18);
    exc(3'd7);
    chk("R10 fiq status", cur_psr, 32'hA000_00D1);
    rd(4'd14, d); chk("R9 fiq link", d, 32'h1C);
    rd(4'd15, d); chk("R9 fiq pc", d, 32'h1C);
    exc(3'd4);
    chk("R8 abt status", cur_psr, 32'hA000_00D7);
    chk("R8 abt saved", sav_psr, 32'hA000_00D1);
    rd(4'd14, d); chk("R9 abt link +8", d, 32'h24);
    rd(4'd15, d); chk("R9 abt pc", d, 32'h10);
    exc(3'd1);
    chk("R8 und mode", cur_psr, 32'hA000_00DB);
    rd(4'd14, d); chk("R9 und link", d, 32'h14);
    exc(3'd0);
    chk("R8 svc mode", cur_psr, 32'hA000_00D3);
    rd(4'd14, d); chk("R9 reset link +0", d, 32'h4);
    rd(4'd15, d); chk("R9 reset pc", d, 0);
    exc(3'd3);
    rd(4'd14, d); chk("R9 code3 link", d, 32'h4);
    rd(4'd15, d); chk("R9 code3 pc", d, 32'hC);
    exc(3'd2);
    chk("R8 code2 svc", cur_psr, 32'hA000_00D3);
    rd(4'd14, d); chk("R9 code2 link", d, 32'h10);
    rd(4'd15, d); chk("R9 code2 pc", d, 32'h8);
  endtask

  task automatic t_reserved();
    logic [XLEN-1:0] d;
    exc(3'd5);
    chk("R11 mode kept", cur_psr, 32'hA000_00D3);
    chk("R11 saved", sav_psr, 32'hA000_00D3);
    rd(4'd14, d); chk("R11 link", d, 32'h8);
    rd(4'd15, d); chk("R11 pc", d, 32'h14);
    setpsr(32'h10);
    exc(3'd5);
    chk("R11 user mode kept", cur_psr, 32'h10);
    chk("R11 user no saved", sav_psr, 0);
  endtask

  task automatic t_prio();
    logic [XLEN-1:0] d;
    wreg(4'd15, 32'h200);
    wr_en = 1; wr_idx = 4'd14; wr_data = 32'hDEAD;
    cur_psr_we = 1; cur_psr_wdata = 32'h1F;
    usr_we = 1; usr_idx = 4'd3; usr_wdata = 32'hBEEF;
    exc(3'd2);
    wr_en = 0; cur_psr_we = 0; usr_we = 0;
    chk("R12 exception wins status", cur_psr, 32'h13);
    rd(4'd14, d); chk("R12 link not overwritten", d, 32'h204);
    rd(4'd3, d);  chk("R12 user write dropped", d, 32'h33);
  endtask

  initial begin
    #200_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_mask();
    t_banks();
    t_saved();
    t_userport();
    t_exc();
    t_reserved();
    t_prio();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule